// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 12-bit control words from a host over three wires: a data line, a shift clock and a latch strobe. All three wires are resampled in the system clock domain. A rising edge of the shift clock appends one data bit. A rising edge of the latch strobe hands over the most recent twelve bits as one word. The leading bit of the word picks the destination. A leading zero writes an 11-bit gain code. A leading one writes the mode flags: six test bits, a rate-update mode bit, a +12 dB boost bit, two de-emphasis rate selects and the de-emphasis enable.

A mode pin decides who controls the outputs. In register mode the stored registers drive them. In pin mode three dedicated pins supply the de-emphasis enable and the two rate selects, the gain is held at unity (0x400), and the other flags read zero. Whenever the decoded de-emphasis rate changes, the block emits a one-cycle pulse. Downstream logic uses this pulse as a mute request.

The receiver is a three-state machine:
- **SH_IDLE**: no bit has arrived since the last latch.
- **SH_FILL**: 1 to 11 bits have arrived.
- **SH_FULL**: 12 or more bits have arrived.

Its transitions are:
- *first bit*: SH_IDLE to SH_FILL.
- *twelfth bit*: SH_FILL to SH_FULL.
- *accept*: SH_FULL to SH_IDLE on a latch. The word is delivered.
- *discard*: SH_FILL or SH_IDLE to SH_IDLE on a latch. Nothing is delivered.
- *restart*: a latch and a shift edge in the same cycle. The word, if any, is taken before the new bit, and the state becomes SH_FILL.

The shift clock and the latch strobe must idle low.

Top module: `sctl_port`

## Requirements
- R1: Data is sampled on each rising edge of the shift clock. Bits arrive MSB first, so the first bit of a word (D1) ends up in word bit 11.
- R2: On a rising edge of the latch strobe, the twelve most recently shifted bits form the word. Any earlier bits are dropped.
- R3: A word with D1=0 loads D2..D12 into the gain code, MSB first. The flags are left unchanged.
- R4: A word with D1=1 loads the flags and leaves the gain code unchanged. The field layout is:
  - D2..D7 go to `test_flags[5:0]`, with D2 in bit 5.
  - D8 goes to `rate_upd_mode`.
  - D9 goes to `gain_boost`.
  - D10 is rate select 1.
  - D11 is rate select 2.
  - D12 goes to `deemph_en`.
- R5: `deemph_fs` encodes the decoded rate as 00 = 44.1 kHz, 01 = 48 kHz and 10 = 32 kHz. The select pair (sel1, sel2) decodes as (0,0) to 00, (1,0) to 01 and (1,1) to 10.
- R6: The select pair (0,1) decodes as 44.1 kHz, code 00.
- R7: After reset, the gain code is 0x400 and every flag output is low.
- R8: `rate_chg` is a one-cycle pulse, given once for each change of the decoded de-emphasis rate. A change of the enable alone, or of the select bits without a change in the decoded rate, gives no pulse.
- R9: When `reg_mode` is low:
  - the gain code reads 0x400;
  - `gain_boost`, `rate_upd_mode` and `test_flags` read zero;
  - the enable and rate come from the pins.
  Words received in this mode still update the registers, and they take effect when `reg_mode` returns high.
- R10: A latch that arrives after fewer than 12 bits since the previous latch is discarded. The bit count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_mode | input | 1 | 1 = outputs from registers, 0 = from pins |
| ser_clk | input | 1 | Serial shift clock (idle low) |
| ser_dat | input | 1 | Serial data |
| ser_latch | input | 1 | Latch strobe (idle low) |
| pin_deemph_en | input | 1 | De-emphasis enable in pin mode |
| pin_rate_sel1 | input | 1 | Rate select 1 in pin mode |
| pin_rate_sel2 | input | 1 | Rate select 2 in pin mode |
| gain_code | output | 11 | Attenuation gain code |
| gain_boost | output | 1 | +12 dB shift flag |
| rate_upd_mode | output | 1 | Rate ratio update mode flag |
| deemph_en | output | 1 | De-emphasis enable |
| deemph_fs | output | 2 | Decoded de-emphasis rate |
| test_flags | output | 6 | Test bits D2..D7 |
| rate_chg | output | 1 | One-cycle pulse on a rate change |

## Verification
Each pin passes through two synchronizer flops, so pin-mode outputs follow the pins two edges later, and `rate_chg` rises on the third edge. A shift-clock edge reaches the shift register on the third system edge. A latch delivers the word on the third edge and the registered outputs on the fourth, and the rate pulse follows on the fifth. The bench holds each serial level for four clocks and lets at least twelve clocks pass after every latch or pin change before it reads any output at a falling edge. It counts `rate_chg` pulses at falling edges, so a stuck or repeated pulse shows up as a wrong count.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W  = 12;
    localparam int GAIN_W  = WORD_W - 1;
    localparam int TEST_W  = 6;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = 11'h400;

    typedef enum logic [1:0] {
        FS_44K1 = 2'b00,
        FS_48K  = 2'b01,
        FS_32K  = 2'b10
    } fs_code_t;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic              upd;
        logic              boost;
        logic              sel1;
        logic              sel2;
        logic              en;
    } flags_t;

    function automatic fs_code_t fs_decode(input logic s1, input logic s2);
        if (s1 && s2)      return FS_32K;
        else if (s1)       return FS_48K;
        else               return FS_44K1;
    endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              slatch_s,
    input  logic              sdat_s,
    output logic              w_vld,
    output logic [WORD_W-1:0] w_word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {SH_IDLE, SH_FILL, SH_FULL} sh_state_t;

    sh_state_t         state, nstate;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;
    logic              sclk_q, slatch_q;
    logic              sclk_rise, latch_rise;
    sh_state_t         after_first;

    assign sclk_rise   = sclk_s & ~sclk_q;
    assign latch_rise  = slatch_s & ~slatch_q;
    assign after_first = (WORD_W == 1) ? SH_FULL : SH_FILL;

    always_comb begin
        nstate = state;
        unique case (state)
            SH_IDLE: if (sclk_rise) nstate = after_first;
            SH_FILL: begin
                if (latch_rise)
                    nstate = sclk_rise ? after_first : SH_IDLE;
                else if (sclk_rise && cnt == CNT_W'(WORD_W - 1))
                    nstate = SH_FULL;
            end
            SH_FULL: if (latch_rise) nstate = sclk_rise ? after_first : SH_IDLE;
            default: nstate = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            slatch_q <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            w_vld    <= 1'b0;
            w_word   <= '0;
        end else begin
            sclk_q   <= sclk_s;
            slatch_q <= slatch_s;
            if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_s};
            if (latch_rise)
                cnt <= sclk_rise ? CNT_W'(1) : '0;
            else if (sclk_rise && cnt != CNT_W'(WORD_W))
                cnt <= cnt + CNT_W'(1);
            w_vld <= latch_rise && (state == SH_FULL);
            if (latch_rise && state == SH_FULL) w_word <= shreg;
        end
    end
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_vld,
    input  logic [WORD_W-1:0] w_word,
    output logic [GAIN_W-1:0] st_gain,
    output flags_t            st_flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_gain  <= GAIN_UNITY;
            st_flags <= '0;
        end else if (w_vld) begin
            if (w_word[WORD_W-1]) st_flags <= flags_t'(w_word[GAIN_W-1:0]);
            else                  st_gain  <= w_word[GAIN_W-1:0];
        end
    end
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_mode,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_latch,
    input  logic        pin_deemph_en,
    input  logic        pin_rate_sel1,
    input  logic        pin_rate_sel2,
    output logic [10:0] gain_code,
    output logic        gain_boost,
    output logic        rate_upd_mode,
    output logic        deemph_en,
    output logic [1:0]  deemph_fs,
    output logic [5:0]  test_flags,
    output logic        rate_chg
);
    localparam int NSYNC = 7;

    logic [NSYNC-1:0]  sync_q;
    logic              mode_s, pen_s, psel1_s, psel2_s, sclk_s, slatch_s, sdat_s;
    logic              w_vld;
    logic [WORD_W-1:0] w_word;
    logic [GAIN_W-1:0] st_gain;
    flags_t            st_flags;
    flags_t            eff;
    fs_code_t          fs_eff, fs_prev;

    sctl_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({reg_mode, pin_deemph_en, pin_rate_sel1, pin_rate_sel2,
                 ser_clk, ser_latch, ser_dat}),
        .q     (sync_q)
    );
    assign {mode_s, pen_s, psel1_s, psel2_s, sclk_s, slatch_s, sdat_s} = sync_q;

    sctl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .slatch_s (slatch_s),
        .sdat_s   (sdat_s),
        .w_vld    (w_vld),
        .w_word   (w_word)
    );

    sctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .w_vld    (w_vld),
        .w_word   (w_word),
        .st_gain  (st_gain),
        .st_flags (st_flags)
    );

    always_comb begin
        if (mode_s) begin
            eff       = st_flags;
            gain_code = st_gain;
        end else begin
            eff       = '0;
            eff.en    = pen_s;
            eff.sel1  = psel1_s;
            eff.sel2  = psel2_s;
            gain_code = GAIN_UNITY;
        end
        fs_eff = fs_decode(eff.sel1, eff.sel2);
    end

    assign gain_boost    = eff.boost;
    assign rate_upd_mode = eff.upd;
    assign deemph_en     = eff.en;
    assign test_flags    = eff.test;
    assign deemph_fs     = fs_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev  <= FS_44K1;
            rate_chg <= 1'b0;
        end else begin
            fs_prev  <= fs_eff;
            rate_chg <= (fs_eff != fs_prev);
        end
    end
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_mode,
    input logic [10:0] gain_code,
    input logic        gain_boost,
    input logic [1:0]  deemph_fs,
    input logic        rate_chg,
    input logic        w_vld,
    input logic [11:0] w_word,
    input logic [10:0] st_gain
);
    assert_gainword_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_vld && !w_word[11]) |=> (st_gain == $past(w_word[10:0])));

    assert_flagword_keeps_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_vld && w_word[11]) |=> $stable(st_gain));

    assert_reset_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_gain == 11'h400));

    assert_rate_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deemph_fs) |=> rate_chg);

    assert_pin_unity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_mode && $past(!reg_mode) && $past(!reg_mode, 2))
            |-> (gain_code == 11'h400 && !gain_boost));
endmodule

bind sctl_port sctl_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_mode  (reg_mode),
    .gain_code (gain_code),
    .gain_boost(gain_boost),
    .deemph_fs (deemph_fs),
    .rate_chg  (rate_chg),
    .w_vld     (w_vld),
    .w_word    (w_word),
    .st_gain   (st_gain)
);

// File: tb/sctl_port_bench.sv
module sctl_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_mode = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
    logic        pin_deemph_en = 1'b0, pin_rate_sel1 = 1'b0, pin_rate_sel2 = 1'b0;
    logic [10:0] gain_code;
    logic        gain_boost, rate_upd_mode, deemph_en, rate_chg;
    logic [1:0]  deemph_fs;
    logic [5:0]  test_flags;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sctl_port u_sctl_port (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_latch(ser_latch),
        .pin_deemph_en(pin_deemph_en), .pin_rate_sel1(pin_rate_sel1),
        .pin_rate_sel2(pin_rate_sel2), .gain_code(gain_code),
        .gain_boost(gain_boost), .rate_upd_mode(rate_upd_mode),
        .deemph_en(deemph_en), .deemph_fs(deemph_fs),
        .test_flags(test_flags), .rate_chg(rate_chg)
    );

    always @(negedge clk) if (rst_n && rate_chg) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            idle(4);
            ser_clk = 1'b1;
            idle(4);
            ser_clk = 1'b0;
        end
        idle(4);
        ser_latch = 1'b1;
        idle(4);
        ser_latch = 1'b0;
        idle(12);
    endtask

    task automatic t_reset;
        chk("R7 gain", gain_code, 11'h400);
        chk("R7 flags", {gain_boost, rate_upd_mode, deemph_en, test_flags}, 0);
        chk("R7 fs", deemph_fs, 2'b00);
        chk("R7 no pulse", pulses, 0);
    endtask

    task automatic t_gain_word;
        send(16'h0123, 12);
        chk("R1 R3 gain", gain_code, 11'h123);
        chk("R3 flags kept", {gain_boost, deemph_en}, 0);
    endtask

    task automatic t_flag_word;
        int p0 = pulses;
        send(16'h081D, 12);
        chk("R4 en/boost/upd", {deemph_en, gain_boost, rate_upd_mode}, 3'b111);
        chk("R5 fs 48k", deemph_fs, 2'b01);
        chk("R4 gain kept", gain_code, 11'h123);
        chk("R8 one pulse", pulses - p0, 1);
        p0 = pulses;
        send(16'h0D5D, 12);
        chk("R4 test bits", test_flags, 6'b101010);
        chk("R8 no pulse same rate", pulses - p0, 0);
    endtask

    task automatic t_short_long;
        send(16'h00FF, 8);
        chk("R10 short discarded", gain_code, 11'h123);
        send(16'h0055, 12);
        chk("R10 count restarts", gain_code, 11'h055);
        send(16'h30AA, 14);
        chk("R2 last twelve", gain_code, 11'h0AA);
    endtask

    task automatic t_rates;
        int p0 = pulses;
        send(16'h081C, 12);
        chk("R8 enable only", pulses - p0, 0);
        chk("R4 enable off", deemph_en, 0);
        p0 = pulses;
        send(16'h081E, 12);
        chk("R5 fs 32k", deemph_fs, 2'b10);
        chk("R8 pulse 32k", pulses - p0, 1);
        p0 = pulses;
        send(16'h0800, 12);
        chk("R5 fs 44k1", deemph_fs, 2'b00);
        chk("R8 pulse 44k1", pulses - p0, 1);
        p0 = pulses;
        send(16'h0802, 12);
        chk("R6 sel 01", deemph_fs, 2'b00);
        chk("R6 no pulse", pulses - p0, 0);
    endtask

    task automatic t_pin_mode;
        int p0 = pulses;
        pin_deemph_en = 1'b1;
        reg_mode = 1'b0;
        idle(12);
        chk("R9 gain unity", gain_code, 11'h400);
        chk("R9 flags zero", {gain_boost, rate_upd_mode, test_flags}, 0);
        chk("R9 pin enable", deemph_en, 1);
        chk("R9 no pulse", pulses - p0, 0);
        send(16'h0010, 12);
        chk("R9 gain held", gain_code, 11'h400);
        p0 = pulses;
        pin_rate_sel1 = 1'b1;
        idle(12);
        chk("R9 pin fs 48k", deemph_fs, 2'b01);
        chk("R8 pin pulse", pulses - p0, 1);
        p0 = pulses;
        reg_mode = 1'b1;
        idle(12);
        chk("R9 stored gain", gain_code, 11'h010);
        chk("R9 back to regs fs", deemph_fs, 2'b00);
        chk("R8 mode pulse", pulses - p0, 1);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(10);
        t_reset();
        t_gain_word();
        t_flag_word();
        t_short_long();
        t_rates();
        t_pin_mode();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule